// File: doc/BRIEF.md
# Framed Serial Word Receiver with Word Clock

This block sits on the receiving end of a narrow serial link and turns it back into a wide parallel bus. Its clock input is the clock forwarded by the transmitter, and it is used directly: one bit slot per rising edge, with no recovery or oversampling. A frame is 26 slots long. It has a high start slot, then 24 data slots carrying the word least significant bit first, then a low stop slot. When the stop slot checks out, the rebuilt word is committed in one step to the parallel outputs. A frame whose stop slot is high is thrown away and flagged with a one-cycle error pulse.

Next to the data, the block drives a word clock for the downstream consumer. The new word appears 8 slots before the word clock falls. The word clock then stays low for exactly 13 slots and goes back high. When frames arrive back to back, this gives 13 slots low and 13 slots high. When frames arrive more slowly, the high phase absorbs the idle time and the low phase does not change.

The block shares a three-pin mode code with the matching transmitter. It drives its outputs only in receive mode. In every other code its output enable is low, so the pads float. Its internal state is also held cleared in those codes, so the outputs read zero and the word clock reads high until the first good frame after re-entry.

Top module: `serial_word_rx`

## Requirements
- R1: The output enable `out_en` is high only when `dir_sel`=0, `mode_a`=1 and `mode_b`=0 (receive mode). For the other seven pin codes it is low, including standby (`mode_a`=`mode_b`=0).
- R2: While idle in receive mode, a high `ser_in` sample starts a frame. The next 24 samples are word bits 0 to 23 in that order. A low 26th sample commits the word to `par_word`, visible after the edge that samples the stop slot. A low line starts nothing.
- R3: A frame whose stop slot is high leaves `par_word` unchanged. It raises `frame_err` for exactly one cycle, after the edge that samples the stop slot.
- R4: `par_word` changes only when a frame is committed, so it never shows a partly shifted word.
- R5: `word_clk` falls exactly 8 slots after the edge that commits a new word.
- R6: Once low, `word_clk` stays low for exactly 13 slots and then returns high.
- R7: With frames back to back (a 26-slot spacing), `word_clk` is high for 13 slots between low phases.
- R8: With spacing P > 26 between committed words, the high phase before the next fall lasts P-13 slots, and the low phase stays 13. A rejected frame in between only lengthens P.
- R9: After reset, and after any period outside receive mode (even one that cuts a frame short), `par_word` reads zero and `word_clk` reads high until the next good frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Forwarded serial clock, one bit slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_sel | input | 1 | Direction pin of the shared mode code (0 selects receive) |
| mode_a | input | 1 | First select pin of the mode code |
| mode_b | input | 1 | Second select pin of the mode code |
| ser_in | input | 1 | Serial data line, sampled on `rx_clk` rising edges |
| par_word | output | 24 | Rebuilt parallel word |
| word_clk | output | 1 | Word clock with fixed lead and low phase |
| out_en | output | 1 | Drive enable for `par_word` and `word_clk`; low means high impedance |
| frame_err | output | 1 | One-cycle pulse when a frame fails its stop-slot check |

## Verification
Two things can happen at the same edge: the word-clock timer finishing the low phase of one word, and the frame engine sampling the start or data slots of the next. With zero gap, a new frame is also shifting while the previous word's lead and low phases run. A rejected stop slot can likewise be followed at once by a start slot. The sweeps send walking-one words with spacings from 26 slots up to well beyond the low phase, with error frames and a mid-frame mode exit mixed in. A port monitor measures lead, low and high lengths against the spacing it observes between word commits, so every overlap is judged by the P-13 rule rather than by a fixed number.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int unsigned DEF_DATA_W = 24;
    localparam int unsigned DEF_LEAD   = 8;
    localparam int unsigned DEF_LOW    = 13;

    typedef enum logic [1:0] {
        LINK_OFF,
        LINK_TX,
        LINK_RX,
        LINK_BAD
    } link_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic link_mode_e decode_mode(input logic dir, input logic sa, input logic sb);
        link_mode_e m;
        if (!sa && !sb)
            m = LINK_OFF;
        else if (dir && !sa && sb)
            m = LINK_TX;
        else if (!dir && sa && !sb)
            m = LINK_RX;
        else
            m = LINK_BAD;
        return m;
    endfunction

endpackage

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_q,
    output logic              take,
    output logic              word_ok,
    output logic              word_bad
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;

    // stop slot is good in this cycle: commit on this edge
    assign take = en && (state == RX_STOP) && !ser_in;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            word_q   <= '0;
            word_ok  <= 1'b0;
            word_bad <= 1'b0;
        end else begin
            word_ok  <= 1'b0;
            word_bad <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (ser_in) begin
                        state   <= RX_DATA;
                        bit_cnt <= '0;
                    end
                end
                RX_DATA: begin
                    shreg <= {ser_in, shreg[DATA_W-1:1]};
                    if (bit_cnt == CNT_W'(DATA_W - 1))
                        state <= RX_STOP;
                    else
                        bit_cnt <= bit_cnt + 1'b1;
                end
                RX_STOP: begin
                    if (!ser_in) begin
                        word_q  <= shreg;
                        word_ok <= 1'b1;
                    end else begin
                        word_bad <= 1'b1;
                    end
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serrx_wclk.sv
module serrx_wclk
    import serrx_pkg::*;
#(
    parameter int unsigned LEAD = DEF_LEAD,
    parameter int unsigned LOW  = DEF_LOW
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic load,
    output logic wclk
);
    localparam int unsigned ENDC = LEAD + LOW;
    localparam int unsigned CW   = $clog2(ENDC + 1);

    logic [CW-1:0] pcnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt <= '0;
            run  <= 1'b0;
            wclk <= 1'b1;
        end else if (load) begin
            pcnt <= CW'(1);
            run  <= 1'b1;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == CW'(LEAD))
                wclk <= 1'b0;
            if (pcnt == CW'(ENDC)) begin
                wclk <= 1'b1;
                run  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
    import serrx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned LEAD   = DEF_LEAD,
    parameter int unsigned LOW    = DEF_LOW
) (
    input  logic              rx_clk,
    input  logic              rst,
    input  logic              dir_sel,
    input  logic              mode_a,
    input  logic              mode_b,
    input  logic              ser_in,
    output logic [DATA_W-1:0] par_word,
    output logic              word_clk,
    output logic              out_en,
    output logic              frame_err
);
    link_mode_e mode;
    logic       rx_en;
    logic       take;
    logic       word_ok;

    assign mode   = decode_mode(dir_sel, mode_a, mode_b);
    assign rx_en  = (mode == LINK_RX);
    assign out_en = rx_en;

    serrx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk     (rx_clk),
        .rst     (rst),
        .en      (rx_en),
        .ser_in  (ser_in),
        .word_q  (par_word),
        .take    (take),
        .word_ok (word_ok),
        .word_bad(frame_err)
    );

    serrx_wclk #(.LEAD(LEAD), .LOW(LOW)) u_wclk (
        .clk (rx_clk),
        .rst (rst),
        .en  (rx_en),
        .load(take),
        .wclk(word_clk)
    );

endmodule

// File: rtl/serrx_chk.sv
module serrx_chk #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned LEAD   = 8,
    parameter int unsigned LOW    = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              word_ok,
    input logic [DATA_W-1:0] par_word,
    input logic              word_clk,
    input logic              frame_err
);
    logic [15:0] since_ok;
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            since_ok <= '1;
            low_run  <= '0;
        end else begin
            if (word_ok)
                since_ok <= 16'd1;
            else if (since_ok != '1)
                since_ok <= since_ok + 16'd1;
            if (!word_clk) begin
                if (low_run != '1)
                    low_run <= low_run + 16'd1;
            end else begin
                low_run <= '0;
            end
        end
    end

    // R9: outside receive mode the outputs settle to zero word, clock high
    a_r9_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (par_word == '0 && word_clk));

    // R4: word changes only together with a commit
    a_r4_word_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $past(rx_en) && !word_ok) |-> $stable(par_word));

    // R3: rejected frame leaves the word alone
    a_r3_err_holds_word: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $stable(par_word));

    // R3: error is a single-cycle pulse
    a_r3_err_single: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R2: a stop slot is either accepted or rejected, never both
    a_r2_ok_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(word_ok && frame_err));

    // R5: falling edge comes LEAD slots after the commit
    a_r5_lead: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $fell(word_clk)) |-> (since_ok == 16'(LEAD)));

    // R6: low phase lasts LOW slots
    a_r6_low_len: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $past(rx_en) && $rose(word_clk)) |-> (low_run == 16'(LOW)));

endmodule

bind serial_word_rx serrx_chk #(.DATA_W(DATA_W), .LEAD(LEAD), .LOW(LOW)) u_chk (
    .clk      (rx_clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .word_ok  (word_ok),
    .par_word (par_word),
    .word_clk (word_clk),
    .frame_err(frame_err)
);

// File: tb/tb_serial_word_rx.sv
module tb_serial_word_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_sel = 1'b0;
    logic        mode_a = 1'b1;
    logic        mode_b = 1'b0;
    logic        ser_in = 1'b0;
    logic [23:0] par_word;
    logic        word_clk;
    logic        out_en;
    logic        frame_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [23:0] last_good = '0;

    always #4 clk = ~clk;

    serial_word_rx dut (
        .rx_clk(clk), .rst(rst), .dir_sel(dir_sel), .mode_a(mode_a), .mode_b(mode_b),
        .ser_in(ser_in), .par_word(par_word), .word_clk(word_clk), .out_en(out_en),
        .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // port monitor for word clock timing
    int cyc = 0, last_upd = 0, prev_upd = 0, last_rise = 0, last_fall = 0, upd_cnt = 0;
    bit have_rise = 0, have_fall = 0;
    logic [23:0] prev_w = '0;
    logic        prev_ck = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst || !out_en) begin
            have_rise = 0; have_fall = 0; upd_cnt = 0;
        end else begin
            if (par_word != prev_w) begin
                prev_upd = last_upd; last_upd = cyc; upd_cnt++;
            end
            if (prev_ck && !word_clk) begin
                chk(upd_cnt > 0 && cyc - last_upd == 8, "R5", 32'(cyc - last_upd), 32'd8);
                if (have_rise && upd_cnt >= 2) begin
                    int p;
                    p = last_upd - prev_upd;
                    chk(cyc - last_rise == p - 13, (p == 26) ? "R7" : "R8",
                        32'(cyc - last_rise), 32'(p - 13));
                end
                last_fall = cyc; have_fall = 1;
            end
            if (!prev_ck && word_clk && have_fall) begin
                chk(cyc - last_fall == 13, "R6", 32'(cyc - last_fall), 32'd13);
                last_rise = cyc; have_rise = 1;
            end
        end
        prev_w = par_word;
        prev_ck = word_clk;
    end

    task automatic send_frame(input logic [23:0] w, input bit bad_stop, input int gap);
        for (int s = 0; s < 26; s++) begin
            @(negedge clk);
            if (s == 13)
                chk(par_word == last_good, "R4", 32'(par_word), 32'(last_good));
            ser_in = (s == 0) ? 1'b1 : (s == 25) ? bad_stop : w[s-1];
        end
        fork
            begin
                @(negedge clk);
                if (!bad_stop) begin
                    chk(par_word == w, "R2", 32'(par_word), 32'(w));
                    chk(frame_err == 1'b0, "R2", 32'(frame_err), 32'd0);
                    last_good = w;
                end else begin
                    chk(frame_err == 1'b1, "R3", 32'(frame_err), 32'd1);
                    chk(par_word == last_good, "R3", 32'(par_word), 32'(last_good));
                    @(negedge clk);
                    chk(frame_err == 1'b0, "R3", 32'(frame_err), 32'd0);
                end
            end
        join_none
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            ser_in = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(par_word == '0, "R9", 32'(par_word), 32'd0);
        chk(word_clk == 1'b1, "R9", 32'(word_clk), 32'd1);
        repeat (40) @(negedge clk);
        chk(par_word == '0 && word_clk, "R9", 32'(par_word), 32'd0);

        // all eight mode pin codes
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            {dir_sel, mode_a, mode_b} = 3'(c);
            @(negedge clk);
            chk(out_en == (c == 3'b010), "R1", 32'(out_en), 32'(c == 3'b010));
        end
        {dir_sel, mode_a, mode_b} = 3'b010;
        repeat (3) @(negedge clk);

        // walking-one sweep with varied spacing
        for (int i = 0; i < 24; i++)
            send_frame(24'h1 << i, 1'b0, (i % 5) * 3 + ((i == 7) ? 40 : 0));
        // pattern frames, back to back, with rejected frames in between
        send_frame(24'hA5A5A5, 1'b0, 0);
        send_frame(24'h123456, 1'b1, 0);
        send_frame(24'h5A5A5A, 1'b0, 0);
        send_frame(24'hFFFFFF, 1'b0, 0);
        send_frame(24'h0F0F0F, 1'b1, 5);
        send_frame(24'hC3C3C3, 1'b0, 30);
        repeat (30) @(negedge clk);

        // leave receive mode in the middle of a frame
        @(negedge clk); ser_in = 1'b1;
        for (int s = 0; s < 10; s++) begin
            @(negedge clk); ser_in = s[0];
        end
        mode_a = 1'b0;
        @(negedge clk);
        ser_in = 1'b0;
        chk(out_en == 1'b0, "R1", 32'(out_en), 32'd0);
        mode_a = 1'b1;
        @(negedge clk);
        chk(par_word == '0, "R9", 32'(par_word), 32'd0);
        chk(word_clk == 1'b1, "R9", 32'(word_clk), 32'd1);
        last_good = '0;
        repeat (30) @(negedge clk);
        chk(par_word == '0 && word_clk, "R9", 32'(par_word), 32'd0);
        send_frame(24'h3C3C3C, 1'b0, 0);
        send_frame(24'h800001, 1'b0, 0);
        repeat (40) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule